// File: doc/BRIEF.md
# Grouped Match-Timer Channel Bank

This block holds eight timer channels, numbered 4 through 11. Each channel owns a 32-bit counter, a 32-bit compare value and a control word. A counter advances on single-cycle tick enables that come from outside the block. The control word picks which tick drives the counter. It can also make the channel compare against a counter shared by its group instead of its own counter. Further control bits clear the counter when a match occurs, re-arm the match periodically, freeze the timebase, and capture the neighbouring counter into a snapshot register when software reads the channel's counter.

Channels fall into three groups for shared counting. Channels 4 to 7 follow channel 4, channels 8 and 9 follow channel 8, and channels 10 and 11 follow channel 10. A match on a channel whose enable bit is set raises that channel's status bit. Status bits sit at positions 4 to 11 and are cleared by writing one to them. A single combined interrupt stays high while any of these status bits is set. Software reaches every register through a simple register port with a write strobe, a read strobe and an 8-bit byte address. Read data is combinational from the address.

Top module: `xtimer_bank`

## Requirements
- R1: After reset, every counter, compare value, control word, the enable mask, the status bits and the snapshot register read 0, and irqOut is low. An address that maps to no register reads 0.
- R2: Control bits [2:0] pick the tick source. Code 1 uses tickEn[0], code 2 tickEn[1], code 3 tickEn[2], code 4 tickEn[3] and code 5 tickEn[4]. Codes 0, 6 and 7 stop the counter. A running counter rises by exactly one on each pulse of its selected tick, and a stopped counter holds its value.
- R3: Counters live at byte addresses 0x40+4k, compare values at 0x80+4k and control words at 0xC0+4k, where k = channel-4. Writing a counter or compare value loads it, and reads return the stored value.
- R4: A channel matches in the cycle when the counter it compares against advances onto the channel's compare value. The match sets status bit n (channel n) only when enable bit n is set. The enable mask is at 0x1C and status is at 0x14, both using bits [11:4].
- R5: With control bit 3 set, a match loads the channel's own counter with 0 instead of letting it keep the matched value.
- R6: With control bit 6 set, a channel matches every time the condition recurs. With bit 6 clear, it matches once and then stays silent until its compare value or control word is written again. Writing the counter does not re-arm it.
- R7: With control bit 7 set, a channel compares against its own counter. With bit 7 clear, it compares against its group leader's counter: channel 4 for channels 4 to 7, channel 8 for channels 8 and 9, and channel 10 for channels 10 and 11. In that case its own counter is frozen, except on a leader.
- R8: Channels 4 to 7 keep only bits [7:0] of a control write, and channels 8 to 11 keep bits [9:0]. On channels 8 to 11, control bit 8 freezes the counter whatever the tick code.
- R9: A read strobe on channel 9's counter while channel 9's control bit 9 is set copies channel 8's counter into the snapshot register at 0x20. Channels 11 and 10 work the same way. Without bit 9, the snapshot register is left unchanged.
- R10: Writing ones to status bits [11:4] clears those bits and leaves the others. A match in the same cycle wins over a clear. irqOut is high exactly while any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 5 | Single-cycle tick enables for the selectable timebases |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (drives snapshot capture) |
| regAddr | input | 8 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| irqOut | output | 1 | Combined interrupt for channels 4 to 11 |

## Verification
The assertions rely on two things about the inputs. Tick enables are pulses that the counters may see in any cycle. Reads and writes are separate, valid strobes on a word-aligned address. Because of this, a counter that neither ticks nor gets written nor matches must hold its value, and a disarmed channel must stay silent. The stimulus drives each tick for exactly one clock. It keeps register writes out of the cycles that carry ticks, so every expected count follows from the number of pulses on the selected source alone. It sets up each scenario from a fresh reset so that channels left running by earlier cases do not disturb it.

// File: rtl/xtmr_pkg.sv
package xtmr_pkg;
  localparam int NUM_CH  = 8;
  localparam int CH_BASE = 4;
  localparam int IDX_W   = $clog2(NUM_CH);
  localparam int CTRL_W  = 10;
  localparam int TB_W    = 5;
  localparam int ADDR_W  = 8;

  localparam int CB_RESET    = 3;
  localparam int CB_PERIODIC = 6;
  localparam int CB_OWN      = 7;
  localparam int CB_HOLD     = 8;
  localparam int CB_SNAP     = 9;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 8'h1C;
  localparam logic [ADDR_W-1:0] ADDR_SNAP   = 8'h20;

  localparam int SNAP_A = 5;
  localparam int SNAP_B = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MATCH, SEL_COUNT, SEL_CTRL, SEL_STATUS, SEL_ENABLE, SEL_SNAP
  } regSel_e;

  typedef struct packed {
    logic             wr;
    logic             rd;
    regSel_e          sel;
    logic [IDX_W-1:0] idx;
  } busStrobe_t;

  function automatic int leaderOf(input int i);
    if (i < 4) return 0;
    else if (i < 6) return 4;
    else return 6;
  endfunction
endpackage

// File: rtl/xtmr_regdec.sv
module xtmr_regdec
  import xtmr_pkg::*;
(
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  output busStrobe_t        strobe
);
  regSel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (regAddr[1:0] == 2'b00) begin
      unique case (regAddr[7:5])
        3'b010:  sel = SEL_COUNT;
        3'b100:  sel = SEL_MATCH;
        3'b110:  sel = SEL_CTRL;
        default: begin
          if (regAddr == ADDR_STATUS)      sel = SEL_STATUS;
          else if (regAddr == ADDR_ENABLE) sel = SEL_ENABLE;
          else if (regAddr == ADDR_SNAP)   sel = SEL_SNAP;
        end
      endcase
    end
  end

  assign strobe.wr  = regWe;
  assign strobe.rd  = regRe;
  assign strobe.sel = sel;
  assign strobe.idx = regAddr[IDX_W+1:2];
endmodule

// File: rtl/xtmr_channel.sv
module xtmr_channel
  import xtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TB_W-1:0]   tickEn,
  input  logic              wrMatch,
  input  logic              wrCount,
  input  logic              wrCtrl,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              srcAdv,
  input  logic [CNT_W-1:0]  srcNext,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  matchVal,
  output logic [CTRL_W-1:0] ctrl,
  output logic              ownAdv,
  output logic [CNT_W-1:0]  ownNext,
  output logic              hit
);
  localparam bit IS_LEADER = (leaderOf(CH_IDX) == CH_IDX);
  localparam bit IS_HIGH   = (CH_IDX >= 4);
  localparam logic [CTRL_W-1:0] CTRL_KEEP = IS_HIGH ? 10'h3FF : 10'h0FF;

  logic armed;
  logic tickSel;
  logic counterOn;

  always_comb begin
    unique case (ctrl[2:0])
      3'd1:    tickSel = tickEn[0];
      3'd2:    tickSel = tickEn[1];
      3'd3:    tickSel = tickEn[2];
      3'd4:    tickSel = tickEn[3];
      3'd5:    tickSel = tickEn[4];
      default: tickSel = 1'b0;
    endcase
  end

  assign counterOn = (ctrl[CB_OWN] || IS_LEADER) && !(IS_HIGH && ctrl[CB_HOLD]);
  assign ownAdv    = counterOn && tickSel;
  assign ownNext   = count + CNT_W'(1);
  assign hit       = armed && srcAdv && (srcNext == matchVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      matchVal <= '0;
      ctrl     <= '0;
      armed    <= 1'b1;
    end else begin
      if (wrCount)                    count <= wdata;
      else if (hit && ctrl[CB_RESET]) count <= '0;
      else if (ownAdv)                count <= ownNext;

      if (wrMatch) matchVal <= wdata;
      if (wrCtrl)  ctrl     <= wdata[CTRL_W-1:0] & CTRL_KEEP;

      if (wrMatch || wrCtrl)              armed <= 1'b1;
      else if (hit && !ctrl[CB_PERIODIC]) armed <= 1'b0;
    end
  end

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (ownAdv && !wrCount && !(hit && ctrl[CB_RESET])) |=> count == $past(count) + CNT_W'(1))
    else $error("R2 counter did not step by one");

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!ownAdv && !wrCount && !hit) |=> $stable(count))
    else $error("R2 idle counter moved");

  a_r5_clear_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (hit && ctrl[CB_RESET] && !wrCount) |=> count == '0)
    else $error("R5 counter not cleared on match");

  a_r6_silent_when_spent: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !wrMatch && !wrCtrl) |=> !hit)
    else $error("R6 disarmed channel matched");

  a_r8_masked_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> ctrl == ($past(wdata[CTRL_W-1:0]) & CTRL_KEEP))
    else $error("R8 control bits not masked");
endmodule

// File: rtl/xtmr_datapath.sv
module xtmr_datapath
  import xtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TB_W-1:0]  tickEn,
  input  busStrobe_t       strobe,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irqOut
);
  logic [NUM_CH-1:0][CNT_W-1:0]  countArr, matchArr, ownNext, srcNext;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlArr;
  logic [NUM_CH-1:0] ownAdv, srcAdv, hitVec;
  logic [NUM_CH-1:0] wrMatchV, wrCountV, wrCtrlV;
  logic [NUM_CH-1:0] status, enable, setMask, clrMask;
  logic [CNT_W-1:0]  snapReg;
  logic              snapTakeA, snapTakeB;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int LEAD = leaderOf(i);

    assign wrMatchV[i] = strobe.wr && strobe.sel == SEL_MATCH && strobe.idx == IDX_W'(i);
    assign wrCountV[i] = strobe.wr && strobe.sel == SEL_COUNT && strobe.idx == IDX_W'(i);
    assign wrCtrlV[i]  = strobe.wr && strobe.sel == SEL_CTRL  && strobe.idx == IDX_W'(i);

    assign srcAdv[i]  = ctrlArr[i][CB_OWN] ? ownAdv[i]  : ownAdv[LEAD];
    assign srcNext[i] = ctrlArr[i][CB_OWN] ? ownNext[i] : ownNext[LEAD];

    xtmr_channel #(.CNT_W(CNT_W), .CH_IDX(i)) u_ch (
      .clk      (clk),
      .rstN     (rstN),
      .tickEn   (tickEn),
      .wrMatch  (wrMatchV[i]),
      .wrCount  (wrCountV[i]),
      .wrCtrl   (wrCtrlV[i]),
      .wdata    (wdata),
      .srcAdv   (srcAdv[i]),
      .srcNext  (srcNext[i]),
      .count    (countArr[i]),
      .matchVal (matchArr[i]),
      .ctrl     (ctrlArr[i]),
      .ownAdv   (ownAdv[i]),
      .ownNext  (ownNext[i]),
      .hit      (hitVec[i])
    );
  end

  assign setMask = hitVec & enable;
  assign clrMask = (strobe.wr && strobe.sel == SEL_STATUS) ? wdata[CH_BASE +: NUM_CH] : '0;

  assign snapTakeA = strobe.rd && strobe.sel == SEL_COUNT &&
                     strobe.idx == IDX_W'(SNAP_A) && ctrlArr[SNAP_A][CB_SNAP];
  assign snapTakeB = strobe.rd && strobe.sel == SEL_COUNT &&
                     strobe.idx == IDX_W'(SNAP_B) && ctrlArr[SNAP_B][CB_SNAP];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status  <= '0;
      enable  <= '0;
      snapReg <= '0;
    end else begin
      status <= (status & ~clrMask) | setMask;
      if (strobe.wr && strobe.sel == SEL_ENABLE) enable <= wdata[CH_BASE +: NUM_CH];
      if (snapTakeA)      snapReg <= countArr[SNAP_A-1];
      else if (snapTakeB) snapReg <= countArr[SNAP_B-1];
    end
  end

  assign irqOut = |status;

  always_comb begin
    rdata = '0;
    unique case (strobe.sel)
      SEL_COUNT:  rdata = countArr[strobe.idx];
      SEL_MATCH:  rdata = matchArr[strobe.idx];
      SEL_CTRL:   rdata[CTRL_W-1:0] = ctrlArr[strobe.idx];
      SEL_STATUS: rdata[CH_BASE +: NUM_CH] = status;
      SEL_ENABLE: rdata[CH_BASE +: NUM_CH] = enable;
      SEL_SNAP:   rdata = snapReg;
      default:    rdata = '0;
    endcase
  end

  a_r4_event_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    (|(hitVec & enable)) |=> irqOut)
    else $error("R4 enabled match did not raise interrupt");

  a_r4_masked_no_status: assert property (@(posedge clk) disable iff (!rstN)
    (status == '0 && (hitVec & enable) == '0) |=> status == '0)
    else $error("R4 status rose without enabled match");

  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (status & $past(clrMask & ~setMask)) == '0)
    else $error("R10 status bit survived a clear");

  a_r9_snapshot_a: assert property (@(posedge clk) disable iff (!rstN)
    snapTakeA |=> snapReg == $past(countArr[SNAP_A-1]))
    else $error("R9 snapshot of leader 8 wrong");

  a_r9_snapshot_b: assert property (@(posedge clk) disable iff (!rstN)
    (snapTakeB && !snapTakeA) |=> snapReg == $past(countArr[SNAP_B-1]))
    else $error("R9 snapshot of leader 10 wrong");
endmodule

// File: rtl/xtimer_bank.sv
module xtimer_bank
  import xtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TB_W-1:0]   tickEn,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic              irqOut
);
  busStrobe_t strobe;

  xtmr_regdec u_dec (
    .regWe   (regWe),
    .regRe   (regRe),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  xtmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .strobe (strobe),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .irqOut (irqOut)
  );
endmodule

// File: tb/tb_xtimer_bank.sv
`timescale 1ns/1ps
module tb_xtimer_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  tickEn = '0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xtimer_bank dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [7:0] aCnt(input int ch);  return 8'(8'h40 + 4*(ch-4)); endfunction
  function automatic logic [7:0] aMat(input int ch);  return 8'(8'h80 + 4*(ch-4)); endfunction
  function automatic logic [7:0] aCtl(input int ch);  return 8'(8'hC0 + 4*(ch-4)); endfunction
  localparam logic [7:0] A_STAT = 8'h14, A_EN = 8'h1C, A_SNAP = 8'h20;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickEn = '0; regWe = 1'b0; regRe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; regRe = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic tick(input logic [4:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      tickEn = m;
      @(negedge clk);
      tickEn = '0;
      @(negedge clk);
    end
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    doReset();
    expectReg("R1 status", A_STAT, 0);
    expectReg("R1 enable", A_EN, 0);
    expectReg("R1 snapshot", A_SNAP, 0);
    expectReg("R1 ctrl ch11", aCtl(11), 0);
    expectReg("R1 count ch4", aCnt(4), 0);
    expectReg("R1 match ch10", aMat(10), 0);
    expectReg("R1 unmapped", 8'h30, 0);
    check("R1 irq", {31'b0, irqOut}, 0);
  endtask

  task automatic testLoad();
    doReset();
    wr(aCnt(7), 32'hDEADBEEF);
    wr(aMat(11), 32'hCAFEF00D);
    expectReg("R3 count ch7", aCnt(7), 32'hDEADBEEF);
    expectReg("R3 match ch11", aMat(11), 32'hCAFEF00D);
  endtask

  task automatic testTimebase();
    doReset();
    wr(aCtl(4), 32'h81);
    tick(5'b00001, 3);
    tick(5'b00010, 2);
    expectReg("R2 code1 ticks", aCnt(4), 3);
    wr(aCtl(4), 32'h85);
    tick(5'b10000, 2);
    expectReg("R2 code5 ticks", aCnt(4), 5);
    wr(aCtl(4), 32'h86);
    tick(5'b11111, 2);
    wr(aCtl(4), 32'h80);
    tick(5'b11111, 1);
    expectReg("R2 stopped codes hold", aCnt(4), 5);
    wr(aCtl(4), 32'h84); tick(5'b01000, 1);
    wr(aCtl(4), 32'h83); tick(5'b00100, 1);
    wr(aCtl(4), 32'h82); tick(5'b00010, 1);
    expectReg("R2 codes 2..4", aCnt(4), 8);
  endtask

  task automatic testMatchEnable();
    doReset();
    wr(aCtl(5), 32'hC2);
    wr(aMat(5), 3);
    tick(5'b00010, 3);
    expectReg("R4 disabled no status", A_STAT, 0);
    wr(A_EN, 32'h20);
    wr(aCnt(5), 0);
    tick(5'b00010, 2);
    expectReg("R4 before match", A_STAT, 0);
    tick(5'b00010, 1);
    expectReg("R4 status on match", A_STAT, 32'h20);
    check("R10 irq high", {31'b0, irqOut}, 1);
  endtask

  task automatic testResetOnMatch();
    doReset();
    wr(A_EN, 32'h40);
    wr(aCtl(6), 32'hCB);
    wr(aMat(6), 2);
    tick(5'b00100, 1);
    expectReg("R5 count before", aCnt(6), 1);
    tick(5'b00100, 1);
    expectReg("R5 count cleared", aCnt(6), 0);
    expectReg("R5 status", A_STAT, 32'h40);
    wr(A_STAT, 32'h40);
    expectReg("R10 cleared", A_STAT, 0);
    tick(5'b00100, 2);
    expectReg("R6 periodic again", A_STAT, 32'h40);
  endtask

  task automatic testOneShot();
    doReset();
    wr(A_EN, 32'h80);
    wr(aCtl(7), 32'h81);
    wr(aMat(7), 2);
    tick(5'b00001, 2);
    expectReg("R6 first shot", A_STAT, 32'h80);
    wr(A_STAT, 32'h80);
    wr(aCnt(7), 0);
    tick(5'b00001, 2);
    expectReg("R6 no second shot", A_STAT, 0);
    wr(aMat(7), 2);
    wr(aCnt(7), 0);
    tick(5'b00001, 2);
    expectReg("R6 rearmed", A_STAT, 32'h80);
  endtask

  task automatic testChain();
    doReset();
    wr(A_EN, 32'h820);
    wr(aCtl(4), 32'h01);
    wr(aCtl(5), 32'h01);
    wr(aCnt(5), 7);
    wr(aMat(5), 3);
    wr(aCtl(10), 32'h02);
    wr(aCtl(11), 32'h02);
    wr(aMat(11), 2);
    tick(5'b00001, 3);
    tick(5'b00010, 2);
    expectReg("R7 chained ch5 and ch11", A_STAT, 32'h820);
    expectReg("R7 follower frozen", aCnt(5), 7);
    expectReg("R7 leader 4 runs", aCnt(4), 3);
    expectReg("R7 leader 10 runs", aCnt(10), 2);
  endtask

  task automatic testMask();
    doReset();
    wr(aCtl(4), 32'hFFFFFFFF);
    expectReg("R8 low group mask", aCtl(4), 32'hFF);
    wr(aCtl(8), 32'hFFFFFFFF);
    expectReg("R8 high group mask", aCtl(8), 32'h3FF);
    wr(aCtl(8), 32'h181);
    wr(aCnt(8), 5);
    tick(5'b00001, 2);
    expectReg("R8 bit8 freezes", aCnt(8), 5);
    wr(aCtl(8), 32'h81);
    tick(5'b00001, 1);
    expectReg("R8 unfrozen", aCnt(8), 6);
  endtask

  task automatic testSnapshot();
    logic [31:0] v;
    doReset();
    wr(aCnt(8), 32'h1234);
    wr(aCnt(10), 32'hBEEF);
    rd(aCnt(9), v);
    expectReg("R9 no capture without bit9", A_SNAP, 0);
    wr(aCtl(9), 32'h200);
    rd(aCnt(9), v);
    expectReg("R9 capture ch8", A_SNAP, 32'h1234);
    rd(aCnt(11), v);
    expectReg("R9 ch11 without bit9", A_SNAP, 32'h1234);
    wr(aCtl(11), 32'h200);
    rd(aCnt(11), v);
    expectReg("R9 capture ch10", A_SNAP, 32'hBEEF);
  endtask

  task automatic testIrqClear();
    doReset();
    wr(A_EN, 32'h30);
    wr(aCtl(4), 32'hC1);
    wr(aCtl(5), 32'hC1);
    wr(aMat(4), 1);
    wr(aMat(5), 1);
    tick(5'b00001, 1);
    expectReg("R10 two bits", A_STAT, 32'h30);
    wr(A_STAT, 32'h10);
    expectReg("R10 partial clear", A_STAT, 32'h20);
    check("R10 irq still high", {31'b0, irqOut}, 1);
    wr(A_STAT, 32'h20);
    check("R10 irq low", {31'b0, irqOut}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testLoad();
    testTimebase();
    testMatchEnable();
    testResetOnMatch();
    testOneShot();
    testChain();
    testMask();
    testSnapshot();
    testIrqClear();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule